// File: doc/BRIEF.md
# Adaptive Delta Reference Counter

This block sets the inductor-current target of a switching regulator that serves several outputs from one inductor. Once per switching period, on a single-cycle strobe, it reads a 3-bit code that measures the summed, rectified error of all outputs and moves a 6-bit reference code, which an external current DAC turns into the peak-current target for the next on-time.

The step follows the error. With no error the reference falls by a programmable amount, so the converter drifts toward its lowest sufficient current. With an error that is not shrinking compared with the previous period, or that has reached a programmable threshold, the reference rises by as many units as the error code's value, so large errors are chased with large steps and small errors with small ones. An error that is present but already falling, and is still under the threshold, leaves the reference alone. The block keeps the previous error sample itself.

Top module: `adaptive_ref_counter`

## Requirements
- R1: Reset (rst_n low) clears ref_code to 0 and clears the stored previous error to 0, so the first strobe after reset with any nonzero error raises ref_code.
- R2: ref_code changes only on a clock edge where cyc_stb is high; the new value shows on ref_code from that edge on, and with cyc_stb low it holds whatever the other inputs do.
- R3: On a strobe with err_code equal to 0, ref_code falls by down_step, where a down_step of 0 counts as a step of 1.
- R4: On a strobe with err_code nonzero and greater than or equal to the stored previous error, ref_code rises by the unsigned value of err_code.
- R5: On a strobe with err_code nonzero and greater than or equal to err_thresh, ref_code rises by the value of err_code even when err_code is below the stored previous error.
- R6: On a strobe with err_code nonzero, below err_thresh and below the stored previous error, ref_code keeps its value.
- R7: A rise that would pass 63 leaves ref_code at 63.
- R8: A fall that would pass below 0 leaves ref_code at 0.
- R9: Every strobe stores its err_code as the previous error for the next strobe, whichever of rise, fall or hold it caused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | One-cycle pulse per switching period |
| err_code | input | 3 | Quantized cumulative error, 0 = no error |
| err_thresh | input | 3 | Error at or above which the reference always rises |
| down_step | input | 3 | Fall amount when there is no error (0 acts as 1) |
| ref_code | output | 6 | Current reference for the DAC |

## Verification
The error is driven as a rising staircase, a flat run of equal codes, and a falling run, each tried with the threshold set above every code and then set low, which separates the trend-driven rise from the threshold-driven rise and from the hold. Zero-error strobes with several down steps, including a step of zero, exercise the fall, and a zero error followed by a small one shows that the stored sample follows every strobe. Long runs of maximum error and of zero error drive the reference into both ends to show clipping instead of wrap, and idle cycles with changing inputs show that nothing moves without a strobe.

// File: rtl/adaptive_ref_counter.sv
module adaptive_ref_counter #(
  parameter int ERR_W  = 3,
  parameter int REF_W  = 6,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_stb,
  input  logic [ERR_W-1:0]  err_code,
  input  logic [ERR_W-1:0]  err_thresh,
  input  logic [STEP_W-1:0] down_step,
  output logic [REF_W-1:0]  ref_code
);
  localparam int SUM_W = REF_W + 1;
  localparam logic [REF_W-1:0] REF_MAX = '1;

  logic [ERR_W-1:0]  prev_err;
  logic              no_err, at_thresh, not_falling;
  logic [STEP_W-1:0] fall_amt;
  logic [SUM_W-1:0]  up_sum;
  logic [REF_W-1:0]  up_val, down_val, next_ref;

  assign no_err      = (err_code == '0);
  assign at_thresh   = (err_code >= err_thresh);
  assign not_falling = (err_code >= prev_err);
  assign fall_amt    = (down_step == '0) ? STEP_W'(1) : down_step;

  assign up_sum   = {1'b0, ref_code} + SUM_W'(err_code);
  assign up_val   = up_sum[REF_W] ? REF_MAX : up_sum[REF_W-1:0];
  assign down_val = (ref_code > REF_W'(fall_amt)) ? ref_code - REF_W'(fall_amt) : '0;

  always_comb begin
    if (no_err)                       next_ref = down_val;
    else if (at_thresh || not_falling) next_ref = up_val;
    else                              next_ref = ref_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_code <= '0;
      prev_err <= '0;
    end else if (cyc_stb) begin
      ref_code <= next_ref;
      prev_err <= err_code;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_stb |=> $stable(ref_code)); // R2

  AST_NO_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && err_code == '0) |=> (ref_code <= $past(ref_code))); // R3

  AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && err_code == '0 && ref_code == '0) |=> (ref_code == '0)); // R8

  AST_RISE_ON_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && err_code != '0 && err_code >= err_thresh) |=> (ref_code >= $past(ref_code))); // R5

  AST_HOLD_FALLING: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && err_code != '0 && err_code < err_thresh && err_code < prev_err) |=> $stable(ref_code)); // R6

  AST_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && err_code != '0 && ref_code == REF_MAX) |=> (ref_code == REF_MAX)); // R7

  AST_SAMPLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_stb |=> (prev_err == $past(err_code))); // R9
endmodule

// File: tb/adaptive_ref_counter_test.sv
module adaptive_ref_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_stb = 1'b0;
  logic [2:0] err_code = '0;
  logic [2:0] err_thresh = 3'd7;
  logic [2:0] down_step = 3'd1;
  logic [5:0] ref_code;

  int errors = 0;
  int checks = 0;
  int mdl_ref = 0;
  int mdl_prev = 0;
  int exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  adaptive_ref_counter uut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .err_code(err_code),
    .err_thresh(err_thresh), .down_step(down_step), .ref_code(ref_code)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: ref_code=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input int e, input int thr, input int m, input string base);
    int mm;
    int v;
    string tag;
    mm = (m == 0) ? 1 : m;
    tag = base;
    if (e == 0) begin
      v = mdl_ref - mm;
      if (v < 0) begin v = 0; tag = "R8"; end
    end else if (e >= thr || e >= mdl_prev) begin
      v = mdl_ref + e;
      if (v > 63) begin v = 63; tag = "R7"; end
    end else begin
      v = mdl_ref;
    end
    mdl_ref = v;
    mdl_prev = e;
    @(negedge clk);
    err_code = 3'(e);
    err_thresh = 3'(thr);
    down_step = 3'(m);
    cyc_stb = 1'b1;
    exp_q.push_back(v);
    tag_q.push_back(tag);
    @(negedge clk);
    cyc_stb = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc_stb && rst_n) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check(-1, 0, "R2 unexpected strobe");
        end else begin
          check(int'(ref_code), exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(int'(ref_code), 0, "R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    // R1: stored previous error is 0 after reset, so a small error rises
    strobe(1, 7, 1, "R1");
    strobe(3, 7, 1, "R4");
    strobe(3, 7, 1, "R4");
    strobe(2, 7, 1, "R6");
    strobe(1, 7, 1, "R6");
    strobe(0, 7, 2, "R3");
    strobe(0, 7, 0, "R3");
    strobe(5, 4, 1, "R4");
    strobe(4, 4, 1, "R5");
    strobe(2, 4, 1, "R6");
    strobe(6, 7, 1, "R4");
    strobe(0, 7, 1, "R3");
    // R9: previous sample is now 0, so error 1 must rise
    strobe(1, 7, 1, "R9");
    strobe(0, 7, 3, "R3");
    // R2: inputs change with no strobe
    @(negedge clk);
    err_code = 3'd7; err_thresh = 3'd1; down_step = 3'd5;
    repeat (4) @(negedge clk);
    check(int'(ref_code), mdl_ref, "R2 idle hold");
    for (int i = 0; i < 11; i++) strobe(7, 7, 1, "R4");
    check(int'(ref_code), 63, "R7 ceiling");
    strobe(6, 1, 1, "R7");
    for (int i = 0; i < 11; i++) strobe(0, 7, 7, "R3");
    check(int'(ref_code), 0, "R8 floor");
    strobe(0, 7, 1, "R8");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check(exp_q.size(), 0, "R2 missing update");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule